// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block sits on the host side of a parallel flash and decides when an embedded program or erase has finished. Once the command sequence has been written (that is, after the last write strobe of the sequence: the fourth one for a program, the sixth one for an erase), the host pulses `start_i`. The pulse carries the kind of operation, an address inside the bank that is busy, and the byte that was programmed. The controller then reads that address over a simple request/acknowledge read port. It reads in pairs. While the flash is working, status bit 6 flips on every read. When two reads in a row return the same bit 6, the controller makes one more read and checks bit 7. For a program, bit 7 must equal bit 7 of the expected byte. For an erase, bit 7 must be 1.

A poll limit sets how many read pairs may be spent. If the limit is used up, the controller stops and pulses `timeout_o` instead of `done_o`. Both results are single-cycle pulses, and the controller is idle again on the next cycle.

The state machine has six states: IDLE, RD_FIRST, RD_SECOND, VERIFY, DONE and TIMEOUT. Its transitions are as follows:
- IDLE goes to RD_FIRST on start.
- RD_FIRST goes to RD_SECOND on an acknowledge.
- RD_SECOND goes to RD_FIRST when the pair toggled and budget remains (toggle-retry). It goes to TIMEOUT when the pair toggled and this was the last pair (budget-out). It goes to VERIFY when the pair did not toggle (settled).
- VERIFY goes to DONE when bit 7 passes (verify-pass). It goes to RD_FIRST when bit 7 fails and budget remains (verify-retry). It goes to TIMEOUT when bit 7 fails and the budget is spent (verify-out).
- DONE and TIMEOUT both return to IDLE unconditionally.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset the controller is idle: `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are all 0.
- R2: A `start_i` pulse seen in IDLE latches `op_erase_i`, `addr_i`, `exp_data_i` and `poll_limit_i`. Changes on these inputs afterwards have no effect, and a `start_i` that arrives while the controller is not idle (including during a DONE or TIMEOUT pulse) is ignored.
- R3: Every read carries the latched address on `rd_addr_o`. `rd_req_o` stays high until `rd_ack_i`, and each cycle with both high completes exactly one read, whose data is taken from `rd_data_i` in that cycle.
- R4: Reads are issued in pairs. If data bit 6 differs between the two reads of a pair, the operation is still running and a new pair follows (unless the limit is reached).
- R5: If bit 6 is equal in both reads of a pair, exactly one further read is made. For a program (`op_erase_i`=0), completion requires its bit 7 to equal bit 7 of the expected byte.
- R6: For an erase (`op_erase_i`=1), completion requires bit 7 of the verify read to be 1, and the expected byte is ignored.
- R7: A failed bit-7 check counts as a spent pair, and polling resumes with a new pair.
- R8: With a latched limit L, at most max(L,1) pairs are read. A toggling last pair, or a failed verify once the pairs are used up, ends with `timeout_o`. A last pair that does not toggle still proceeds to verify, and can end in `done_o`.
- R9: `done_o` and `timeout_o` are single-cycle pulses that are never high together. `busy_o` is high from the cycle after start through the pulse, and low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling (honoured only in IDLE) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| addr_i | input | ADDR_W | Address inside the busy bank |
| exp_data_i | input | 8 | Byte that was programmed |
| poll_limit_i | input | CNT_W | Maximum read pairs (0 acts as 1) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | 8 | Read data from flash |
| busy_o | output | 1 | Controller not idle |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Poll limit exhausted pulse |

## Verification
Two outcomes can meet in one cycle. The pair that spends the last of the poll budget can also be the pair in which bit 6 stops toggling. The bench provokes this with a flash model whose busy period ends exactly at the final allowed pair, and requires `done_o` rather than `timeout_o`. It also checks that one pair less ends in a timeout. A second collision is a new `start_i` driven during the DONE pulse. That start is judged ignored when `busy_o` stays low and no read is requested afterwards.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_FIRST,
        ST_RD_SECOND,
        ST_VERIFY,
        ST_DONE,
        ST_TIMEOUT
    } poll_state_e;

    localparam int POLL_BIT = 7;
    localparam int TOGGLE_BIT = 6;
endpackage

// File: rtl/poll_status_eval.sv
module poll_status_eval
    import flash_poll_pkg::*;
(
    input  logic [7:0] data_i,
    input  logic       first_toggle_i,
    input  logic       is_erase_i,
    input  logic       exp_poll_i,
    output logic       toggled_o,
    output logic       poll_ok_o
);
    always_comb begin
        toggled_o = data_i[TOGGLE_BIT] ^ first_toggle_i;
        poll_ok_o = is_erase_i ? data_i[POLL_BIT] : (data_i[POLL_BIT] == exp_poll_i);
    end
endmodule

// File: rtl/poll_pair_counter.sv
module poll_pair_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             incr_i,
    output logic             last_pair_o,
    output logic             spent_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] lim_eff;

    always_comb begin
        lim_eff     = (lim_q == '0) ? ONE : lim_q;
        last_pair_o = ({1'b0, cnt_q} + {1'b0, ONE}) >= {1'b0, lim_eff};
        spent_o     = cnt_q >= lim_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
            lim_q <= limit_i;
        end else if (incr_i) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R8
    cnt_within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_eff);
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        exp_data_i,
    input  logic [CNT_W-1:0]  poll_limit_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [7:0]        rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o
);
    poll_state_e       state_q, state_d;
    logic              erase_q;
    logic [ADDR_W-1:0] addr_q;
    logic              exp_poll_q;
    logic              first_tgl_q;
    logic              accept;
    logic              xfer;
    logic              toggled;
    logic              poll_ok;
    logic              last_pair;
    logic              spent;

    assign accept = start_i && (state_q == ST_IDLE);
    assign xfer   = rd_req_o && rd_ack_i;

    poll_status_eval u_eval (
        .data_i         (rd_data_i),
        .first_toggle_i (first_tgl_q),
        .is_erase_i     (erase_q),
        .exp_poll_i     (exp_poll_q),
        .toggled_o      (toggled),
        .poll_ok_o      (poll_ok)
    );

    poll_pair_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (accept),
        .limit_i     (poll_limit_i),
        .incr_i      (xfer && (state_q == ST_RD_SECOND)),
        .last_pair_o (last_pair),
        .spent_o     (spent)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_RD_FIRST;
            ST_RD_FIRST:  if (xfer) state_d = ST_RD_SECOND;
            ST_RD_SECOND: if (xfer) begin
                if (!toggled)      state_d = ST_VERIFY;
                else if (last_pair) state_d = ST_TIMEOUT;
                else               state_d = ST_RD_FIRST;
            end
            ST_VERIFY:    if (xfer) begin
                if (poll_ok)    state_d = ST_DONE;
                else if (spent) state_d = ST_TIMEOUT;
                else            state_d = ST_RD_FIRST;
            end
            ST_DONE:      state_d = ST_IDLE;
            ST_TIMEOUT:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            erase_q     <= 1'b0;
            addr_q      <= '0;
            exp_poll_q  <= 1'b0;
            first_tgl_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                erase_q    <= op_erase_i;
                addr_q     <= addr_i;
                exp_poll_q <= exp_data_i[POLL_BIT];
            end
            if (xfer && (state_q == ST_RD_FIRST))
                first_tgl_q <= rd_data_i[TOGGLE_BIT];
        end
    end

    always_comb begin
        rd_req_o  = (state_q == ST_RD_FIRST) || (state_q == ST_RD_SECOND) ||
                    (state_q == ST_VERIFY);
        rd_addr_o = addr_q;
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_DONE);
        timeout_o = (state_q == ST_TIMEOUT);
    end

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));
    // R9
    pulse_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || timeout_o) |=> !busy_o);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);
    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(rd_addr_o));
    // R5
    done_after_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(state_q == ST_VERIFY && rd_ack_i));
endmodule

// File: tb/flash_poll_ctrl_test.sv
module flash_poll_ctrl_test;
    localparam int ADDR_W = 20;
    localparam int CNT_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              op_erase_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [7:0]        exp_data_i = '0;
    logic [CNT_W-1:0]  poll_limit_i = '0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic [7:0]        rd_data_i = '0;
    logic              busy_o, done_o, timeout_o;

    int tests = 0;
    int fails = 0;

    // flash model settings
    int          m_busy_reads = 0;
    int          m_wait = 0;
    logic        m_erase = 1'b0;
    logic [7:0]  m_exp = '0;
    logic [7:0]  m_final = '0;
    logic [ADDR_W-1:0] m_addr = '0;
    int          rd_idx = 0;
    int          addr_err = 0;
    int          wcnt = 0;

    always #10 clk = ~clk;

    flash_poll_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .addr_i(addr_i), .exp_data_i(exp_data_i), .poll_limit_i(poll_limit_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
        .rd_data_i(rd_data_i), .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o)
    );

    function automatic logic [7:0] model_data(int idx);
        logic [7:0] d;
        if (idx < m_busy_reads) begin
            d = 8'h15 ^ 8'(idx * 8'h09);
            d[7] = m_erase ? 1'b0 : ~m_exp[7];
            d[6] = idx[0];
        end else begin
            d = m_final;
        end
        return d;
    endfunction

    always @(negedge clk) begin
        if (rd_ack_i) begin
            rd_ack_i = 1'b0;
        end else if (rd_req_o) begin
            if (wcnt >= m_wait) begin
                wcnt = 0;
                if (rd_addr_o !== m_addr) addr_err++;
                rd_data_i = model_data(rd_idx);
                rd_ack_i = 1'b1;
                rd_idx++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic launch(logic erase, logic [ADDR_W-1:0] a, logic [7:0] e,
                          int lim, int busy_reads, int wt, logic [7:0] fin);
        @(negedge clk);
        m_erase = erase; m_exp = e; m_final = fin; m_addr = a;
        m_busy_reads = busy_reads; m_wait = wt;
        rd_idx = 0; addr_err = 0; wcnt = 0;
        op_erase_i = erase; addr_i = a; exp_data_i = e;
        poll_limit_i = CNT_W'(lim); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // waits for the result pulse; returns 1 = done, 2 = timeout, 0 = hang
    task automatic wait_end(output int res);
        res = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done_o || timeout_o) begin
                res = done_o ? 1 : 2;
                check("R9", "pulses exclusive", int'(done_o && timeout_o), 0);
                @(negedge clk);
                check("R9", "single-cycle pulse", int'(done_o || timeout_o), 0);
                check("R9", "idle after pulse", int'(busy_o), 0);
                return;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check("R1", "busy after reset", int'(busy_o), 0);
        check("R1", "req after reset", int'(rd_req_o), 0);
        check("R1", "done after reset", int'(done_o), 0);
        check("R1", "timeout after reset", int'(timeout_o), 0);
    endtask

    task automatic t_program_basic();
        int r;
        launch(1'b0, 20'h1A2B3, 8'hA5, 10, 4, 0, 8'hA5);
        check("R9", "busy after start", int'(busy_o), 1);
        wait_end(r);
        check("R5", "program completes", r, 1);
        check("R4", "reads for 4 busy reads", rd_idx, 7);
        check("R3", "address errors", addr_err, 0);
    endtask

    task automatic t_program_waits_and_latch();
        int r;
        launch(1'b0, 20'h0F00D, 8'h3C, 10, 6, 2, 8'h3C);
        addr_i = 20'h55555; exp_data_i = 8'hC3; op_erase_i = 1'b1; poll_limit_i = '0;
        repeat (5) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_end(r);
        check("R2", "latched inputs, late start ignored", r, 1);
        check("R3", "reads with wait states", rd_idx, 9);
        check("R2", "address errors after input change", addr_err, 0);
    endtask

    task automatic t_erase();
        int r;
        launch(1'b1, 20'h40000, 8'h00, 10, 2, 1, 8'hFF);
        wait_end(r);
        check("R6", "erase completes, expected byte ignored", r, 1);
        check("R6", "erase read count", rd_idx, 5);
    endtask

    task automatic t_timeout();
        int r;
        launch(1'b0, 20'h00123, 8'h11, 3, 20, 0, 8'h11);
        wait_end(r);
        check("R8", "limit 3 toggling -> timeout", r, 2);
        check("R8", "reads before timeout", rd_idx, 6);
    endtask

    task automatic t_limit_zero();
        int r;
        launch(1'b0, 20'h00456, 8'h11, 0, 20, 0, 8'h11);
        wait_end(r);
        check("R8", "limit 0 -> timeout", r, 2);
        check("R8", "limit 0 acts as one pair", rd_idx, 2);
    endtask

    task automatic t_verify_fail();
        int r;
        launch(1'b0, 20'h00789, 8'h80, 3, 0, 0, 8'h00);
        wait_end(r);
        check("R7", "bit7 mismatch -> timeout", r, 2);
        check("R7", "pair plus verify per retry", rd_idx, 9);
    endtask

    task automatic t_last_pair_settles();
        int r;
        launch(1'b0, 20'h0ABCD, 8'h5A, 3, 4, 0, 8'h5A);
        wait_end(r);
        check("R8", "settling on last pair -> done", r, 1);
        check("R8", "reads on last pair", rd_idx, 7);
        launch(1'b0, 20'h0ABCD, 8'h5A, 2, 4, 0, 8'h5A);
        wait_end(r);
        check("R8", "one pair short -> timeout", r, 2);
    endtask

    task automatic t_start_during_done();
        int r = 0;
        launch(1'b0, 20'h00ACE, 8'h77, 10, 2, 0, 8'h77);
        for (int i = 0; i < 3000 && !done_o; i++) @(negedge clk);
        check("R9", "done seen", int'(done_o), 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2", "start in done pulse ignored", int'(busy_o), 0);
        r = rd_idx;
        repeat (4) @(negedge clk);
        check("R2", "no reads after ignored start", rd_idx, r);
        check("R2", "req stays low", int'(rd_req_o), 0);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program_basic();
        t_program_waits_and_latch();
        t_erase();
        t_timeout();
        t_limit_zero();
        t_verify_fail();
        t_last_pair_settles();
        t_start_during_done();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule